// File: doc/BRIEF.md
# Modem Control and Status Unit

This block holds the modem control settings of a serial port and reports the state of the four modem status lines together with sticky change flags. The host writes a control byte that selects the data-terminal-ready, request-to-send and two general output levels, plus a loopback switch. The four external status inputs (clear-to-send, data-set-ready, carrier-detect, ring) are brought into the clock domain through a multi-flop synchronizer. Each status bit is compared with its previous value, and a change sets a flag in the low half of the status byte.

A read strobe from the host clears all change flags on the following edge. A change that lands on that same edge is kept. The ring flag behaves differently from the other three: it records only a falling ring line. In loopback the control outputs feed the status bits through a fixed cross mapping. The external pins are then driven inactive and the external inputs have no effect. A single "any change" output goes to the interrupt logic.

Top module: `mdm_ctrl_status`

## Requirements
- R1: After reset the control read value mcr_o is 0x08 (only the general output 2 set), the status read value msr_o is 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags) and delta_any_o is 0.
- R2: msr_o bits 7..4 carry carrier, ring, data-set-ready and clear-to-send. Bits 3, 1 and 0 are set when carrier, data-set-ready or clear-to-send change level in either direction. Outside loopback an external input change shows on msr_o after SYNC_STAGES+1 rising edges.
- R3: Bit 2 of msr_o is set only when ring goes from 1 to 0; a rising ring sets no flag.
- R4: A cycle with msr_rd_i high clears all four change flags on the next edge. A change detected on that same edge still sets its flag.
- R5: A control write keeps only wdata bits 4..0 (bit0 data-terminal-ready, bit1 request-to-send, bit2 general output 1, bit3 general output 2, bit4 loopback). mcr_o reads bits 7..5 as 0. Outside loopback dtr_o, rts_o, out1_o and out2_o follow bits 0..3.
- R6: In loopback the status bits are taken from the control register one edge after it changes: carrier = output 2, ring = output 1, data-set-ready = data-terminal-ready, clear-to-send = request-to-send. Changes set flags as in R2 and R3.
- R7: In loopback dtr_o, rts_o, out1_o and out2_o are 0, and the external status inputs do not change msr_o.
- R8: delta_any_o is high exactly when any of msr_o bits 3..0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcr_we_i | input | 1 | Control register write strobe |
| mcr_wdata_i | input | 8 | Control register write data |
| msr_rd_i | input | 1 | Status read strobe; clears change flags |
| cts_i | input | 1 | External clear-to-send, asynchronous |
| dsr_i | input | 1 | External data-set-ready, asynchronous |
| dcd_i | input | 1 | External carrier detect, asynchronous |
| ri_i | input | 1 | External ring indicator, asynchronous |
| mcr_o | output | 8 | Control register read value |
| msr_o | output | 8 | Status read value: levels in 7..4, flags in 3..0 |
| dtr_o | output | 1 | Data-terminal-ready pin |
| rts_o | output | 1 | Request-to-send pin |
| out1_o | output | 1 | General output 1 pin |
| out2_o | output | 1 | General output 2 pin |
| delta_any_o | output | 1 | Any change flag pending |

## Verification
The external lines are driven in single-bit steps, in a two-bit simultaneous step, and as a ring pulse up and then down. This separates level tracking from flag setting and shows that the ring flag reacts only to the falling edge. Loopback is entered with a control value whose pattern tells the cross mapping apart from a straight mapping. External toggles made while in loopback must leave msr_o unchanged. One control write is timed so that its status change lands on the same edge as a read clear, which shows that a set wins over a clear. Leaving loopback shows that the external levels come back with the right flags.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NSTAT = 4;
  // status nibble bit positions (also the flag positions)
  localparam int CTS_B = 0;
  localparam int DSR_B = 1;
  localparam int RI_B  = 2;
  localparam int DCD_B = 3;
  localparam int MCR_W = 5;
  localparam logic [NSTAT-1:0] STAT_RST = 4'b1011;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcr_t;

  localparam mcr_t MCR_RST = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output mcr_t       mcr_o,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o
);
  mcr_t mcr_q;
  logic unused_hi;
  assign unused_hi = ^wdata_i[7:MCR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcr_q <= MCR_RST;
    else if (we_i) mcr_q <= mcr_t'(wdata_i[MCR_W-1:0]);
  end

  // loopback isolates the external pins
  assign dtr_o  = mcr_q.dtr  & ~mcr_q.loop;
  assign rts_o  = mcr_q.rts  & ~mcr_q.loop;
  assign out1_o = mcr_q.out1 & ~mcr_q.loop;
  assign out2_o = mcr_q.out2 & ~mcr_q.loop;
  assign mcr_o  = mcr_q;
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSTAT-1:0] ext_i,
  input  mcr_t             mcr_i,
  input  logic             rd_i,
  output logic [NSTAT-1:0] sts_o,
  output logic [NSTAT-1:0] delta_o
);
  logic [NSTAT-1:0] lb_sts, nxt_sts, hit, sts_q, delta_q, delta_d;

  always_comb begin
    lb_sts        = '0;
    lb_sts[DCD_B] = mcr_i.out2;
    lb_sts[RI_B]  = mcr_i.out1;
    lb_sts[DSR_B] = mcr_i.dtr;
    lb_sts[CTS_B] = mcr_i.rts;
  end

  assign nxt_sts = mcr_i.loop ? lb_sts : ext_i;

  for (genvar i = 0; i < NSTAT; i++) begin : g_edge
    if (i == RI_B) begin : g_fall
      assign hit[i] = sts_q[i] & ~nxt_sts[i];
    end else begin : g_any
      assign hit[i] = sts_q[i] ^ nxt_sts[i];
    end
    // a new change wins over a read clear
    assign delta_d[i] = (delta_q[i] & ~rd_i) | hit[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= STAT_RST;
      delta_q <= '0;
    end else begin
      sts_q   <= nxt_sts;
      delta_q <= delta_d;
    end
  end

  assign sts_o   = sts_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/mdm_ctrl_status.sv
module mdm_ctrl_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mcr_we_i,
  input  logic [7:0] mcr_wdata_i,
  input  logic       msr_rd_i,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       dcd_i,
  input  logic       ri_i,
  output logic [7:0] mcr_o,
  output logic [7:0] msr_o,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       delta_any_o
);
  logic [NSTAT-1:0] ext_raw, ext_sync, sts, delta;
  mcr_t mcr;

  always_comb begin
    ext_raw        = '0;
    ext_raw[CTS_B] = cts_i;
    ext_raw[DSR_B] = dsr_i;
    ext_raw[RI_B]  = ri_i;
    ext_raw[DCD_B] = dcd_i;
  end

  mdm_sync #(.WIDTH(NSTAT), .STAGES(SYNC_STAGES), .RST_VAL(STAT_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_raw), .q_o(ext_sync)
  );

  mdm_ctrl_reg u_mcr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mcr_we_i), .wdata_i(mcr_wdata_i),
    .mcr_o(mcr), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o)
  );

  mdm_status u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_sync), .mcr_i(mcr),
    .rd_i(msr_rd_i), .sts_o(sts), .delta_o(delta)
  );

  assign mcr_o       = {{(8-MCR_W){1'b0}}, mcr};
  assign msr_o       = {sts, delta};
  assign delta_any_o = |delta;
endmodule

// File: rtl/mdm_ctrl_status_chk.sv
module mdm_ctrl_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mcr_we_i,
  input logic [7:0] mcr_wdata_i,
  input logic       msr_rd_i,
  input logic       cts_i,
  input logic       dsr_i,
  input logic       dcd_i,
  input logic       ri_i,
  input logic [7:0] mcr_o,
  input logic [7:0] msr_o,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o,
  input logic       delta_any_o
);
  logic unused_chk;
  assign unused_chk = ^{mcr_we_i, mcr_wdata_i, cts_i, dsr_i, dcd_i, ri_i};

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(msr_o[7:4]) |-> (((msr_o[7:4] ^ $past(msr_o[7:4])) & 4'b1011 & ~msr_o[3:0]) == 4'b0)); // R2

  AST_NO_SPURIOUS_CTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[0]) |-> (msr_o[4] != $past(msr_o[4]))); // R2

  AST_RING_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[2]) |-> ($past(msr_o[6]) && !msr_o[6])); // R3

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(msr_rd_i) && $stable(msr_o[7:4])) |-> (msr_o[3:0] == 4'b0)); // R4

  AST_MCR_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[7:5] == 3'b0); // R5

  AST_LOOP_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcr_o[4] && $past(mcr_o[4])) |->
      (msr_o[7:4] == {$past(mcr_o[3]), $past(mcr_o[2]), $past(mcr_o[0]), $past(mcr_o[1])})); // R6

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[4] |-> ({dtr_o, rts_o, out1_o, out2_o} == 4'b0)); // R7

  AST_ANY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_any_o == (msr_o[3:0] != 4'b0)); // R8
endmodule

bind mdm_ctrl_status mdm_ctrl_status_chk u_chk (.*);

// File: tb/sim_mdm_ctrl_status.sv
`timescale 1ns/1ps
module sim_mdm_ctrl_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mcr_we = 1'b0;
  logic [7:0] mcr_wdata = 8'h00;
  logic msr_rd = 1'b0;
  logic cts = 1'b1, dsr = 1'b1, dcd = 1'b1, ri = 1'b0;
  logic [7:0] mcr_rd, msr_rd_val;
  logic dtr, rts, out1, out2, any_d;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int        sel;   // 0 msr, 1 mcr, 2 pins {out2,out1,rts,dtr}, 3 any
    logic [7:0] exp;
    string     tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_ctrl_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .mcr_we_i(mcr_we), .mcr_wdata_i(mcr_wdata),
    .msr_rd_i(msr_rd), .cts_i(cts), .dsr_i(dsr), .dcd_i(dcd), .ri_i(ri),
    .mcr_o(mcr_rd), .msr_o(msr_rd_val), .dtr_o(dtr), .rts_o(rts),
    .out1_o(out1), .out2_o(out2), .delta_any_o(any_d)
  );

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = msr_rd_val;
        1: act = mcr_rd;
        2: act = {4'b0, out2, out1, rts, dtr};
        default: act = {7'b0, any_d};
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic write_mcr(input logic [7:0] v);
    @(posedge clk); #1;
    mcr_we = 1'b1; mcr_wdata = v;
    @(posedge clk); #1;
    mcr_we = 1'b0;
  endtask

  task automatic read_msr();
    @(posedge clk); #1;
    msr_rd = 1'b1;
    @(posedge clk); #1;
    msr_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    expect_val(1, 8'h08, "R1 mcr reset");
    expect_val(0, 8'hB0, "R1 msr reset");
    expect_val(3, 8'h00, "R1 any reset");
    expect_val(2, 8'h08, "R5 pins reset");
    settle();

    // R2 single line, latency SYNC_STAGES+1 = 3 edges
    @(posedge clk); #1; cts = 1'b0;
    cycles(2);
    expect_val(0, 8'hB0, "R2 not yet visible after 2 edges");
    settle();
    @(posedge clk); #1;
    expect_val(0, 8'hA1, "R2 cts fall flag");
    expect_val(3, 8'h01, "R8 any set");
    settle();
    read_msr();
    expect_val(0, 8'hA0, "R4 read clears");
    expect_val(3, 8'h00, "R8 any clear");
    settle();

    // R3 ring rise: no flag, fall: flag
    @(posedge clk); #1; ri = 1'b1; cycles(4);
    expect_val(0, 8'hE0, "R3 ring rise no flag");
    settle();
    @(posedge clk); #1; ri = 1'b0; cycles(4);
    expect_val(0, 8'hA4, "R3 ring fall flag");
    settle();
    read_msr();

    // R2 two lines at once
    @(posedge clk); #1; dcd = 1'b0; dsr = 1'b0; cycles(4);
    expect_val(0, 8'h0A, "R2 dcd+dsr fall");
    settle();
    read_msr();
    @(posedge clk); #1; dcd = 1'b1; dsr = 1'b1; cts = 1'b1; cycles(4);
    expect_val(0, 8'hBB, "R2 three rises");
    settle();
    read_msr();
    expect_val(0, 8'hB0, "R4 read clears three");
    settle();

    // R5 upper bits dropped, pins follow
    write_mcr(8'hE3);
    expect_val(1, 8'h03, "R5 mcr low bits only");
    expect_val(2, 8'h03, "R5 pins follow");
    settle();

    // R6/R7 loopback: out2=1 out1=1 rts=0 dtr=1
    write_mcr(8'h1D);
    cycles(1);
    expect_val(1, 8'h1D, "R5 mcr loop value");
    expect_val(2, 8'h00, "R7 pins idle in loop");
    expect_val(0, 8'hE1, "R6 loop cross map");
    settle();
    @(posedge clk); #1; cts = 1'b0; ri = 1'b1; cycles(5);
    expect_val(0, 8'hE1, "R7 external ignored in loop");
    settle();
    read_msr();
    write_mcr(8'h1F);
    cycles(1);
    expect_val(0, 8'hF1, "R6 rts to cts");
    settle();

    // R4 read and change on the same edge
    @(posedge clk); #1;
    mcr_we = 1'b1; mcr_wdata = 8'h1B;
    @(posedge clk); #1;
    mcr_we = 1'b0; msr_rd = 1'b1;
    @(posedge clk); #1;
    msr_rd = 1'b0;
    expect_val(0, 8'hB4, "R4 set wins over clear");
    settle();
    read_msr();

    // leave loopback: external cts=0 ri=1 dsr=1 dcd=1
    write_mcr(8'h08);
    cycles(1);
    expect_val(0, 8'hE1, "R7 external restored");
    expect_val(2, 8'h08, "R5 pins after loop");
    settle();

    cycles(2);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule